// File: doc/BRIEF.md
# Dual-Role Port Ownership Sequencer

This block decides which role one USB port plays at any moment: nobody (detached), host or device. When the port is attached it enters the requested role and owns the port's host-side resources if it is host. A later request for the other role is never applied as a direct mode flip. The sequencer first stops new transfer admission and asks the transfer queues to drain. It then switches the role and strobes a reinitialise of the role-owned contexts. Finally it starts a short progress probe and only re-admits traffic in the new role when that probe passes.

The queues, the datapath and the probe logic are outside this block. Each one is reached through a handshake input: drain complete, commit complete, and probe pass or fail. The drain wait and the probe wait each have a cycle budget set at the ports. A budget that runs out, or a failed probe, sends the port through a short fixed recovery state and then back to detached. A sticky flag records whether the most recent swap succeeded. All outputs are registers with a synchronous active-high reset.

Top module: `drd_role_seq`

## Requirements
- R1: During and right after reset, `state_o` is 0 (detached) and every other output is 0.
- R2: In detached, a rising edge of `attach_i` moves the port to host (`state_o`=1) when `req_host_i`=1, or to device (`state_o`=2) when `req_host_i`=0, on the next clock edge. `admit_o` is 1 in both of these states.
- R3: `sof_en_o`, `port_rst_en_o` and `addr_en_o` are 1 exactly while `state_o` is host (1), and 0 in every other state.
- R4: In host, a `role_req_i` pulse with `req_host_i`=0 moves to swap-prep (`state_o`=3). In device, a pulse with `req_host_i`=1 does the same. In swap-prep `admit_o`=0, `drain_req_o`=1, and `role_host_o` keeps the old role.
- R5: A role request that names the role already active is ignored. So is any request in a state other than host or device. The state and outputs stay unchanged.
- R6: In swap-prep, `drain_done_i` moves the port to commit (`state_o`=4) on the next edge. In that same cycle `ctx_reinit_o` pulses high for exactly one cycle and `role_host_o` takes the requested role (1 = host).
- R7: In commit, the port waits for `commit_done_i` and then enters health-probe (`state_o`=5). `probe_start_o` pulses high for one cycle on entry.
- R8: In health-probe, `probe_pass_i` moves to the requested role's state, sets `admit_o`=1 and sets `swap_ok_o`=1. Pass wins if pass and fail arrive together.
- R9: In health-probe, `probe_fail_i` moves to error-recover (`state_o`=6) and clears `swap_ok_o`. So does receiving no result by the cycle in which the in-state cycle count equals `probe_limit_i`; that cycle count starts at 0 on entry.
- R10: In swap-prep, if no `drain_done_i` has arrived by the cycle in which the in-state count equals `prep_limit_i`, the port moves to error-recover.
- R11: Error-recover lasts `REC_CYCLES`+1 cycles and then enters detached with all outputs idle. While detached, the port does not attach again until it sees a new rising edge of `attach_i`.
- R12: `attach_i`=0 forces detached on the next edge from any state. This has priority over every other input.
- R13: The `state_o` encoding is: 0 detached, 1 host, 2 device, 3 swap-prep, 4 commit, 5 health-probe, 6 error-recover.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| attach_i | input | 1 | Port attached level; a rising edge is an attach event, and low means detach |
| role_req_i | input | 1 | Role request pulse |
| req_host_i | input | 1 | Requested role: 1 host, 0 device |
| drain_done_i | input | 1 | Transfer queues have reached a stable boundary |
| commit_done_i | input | 1 | Datapath has switched mode |
| probe_pass_i | input | 1 | Progress probe succeeded |
| probe_fail_i | input | 1 | Progress probe failed |
| prep_limit_i | input | TW | Cycle budget for swap-prep |
| probe_limit_i | input | TW | Cycle budget for health-probe |
| admit_o | output | 1 | New transfers may be admitted |
| drain_req_o | output | 1 | Request to finish or cancel in-flight work |
| role_host_o | output | 1 | Active role mode: 1 host, 0 device or none |
| ctx_reinit_o | output | 1 | One-cycle reinitialise strobe for role-owned contexts |
| probe_start_o | output | 1 | One-cycle start strobe for the progress probe |
| sof_en_o | output | 1 | Frame-timing generation enable (host only) |
| port_rst_en_o | output | 1 | Port reset drive enable (host only) |
| addr_en_o | output | 1 | Address assignment enable (host only) |
| state_o | output | 3 | Current state encoding |
| swap_ok_o | output | 1 | Sticky outcome of the last swap |

## Verification
Every output is a register written from the next state, so a wrong state value shows at the ports on the very next clock. It shows as a wrong `state_o` code, or as admit, drain or host-enable levels that disagree with that code. A wrong target-role register shows one clock after a drain completes, as the wrong `role_host_o` in commit. It shows again when the probe passes, as the wrong final state. A timeout counter that is off by one shifts the cycle in which the port enters error-recover. The bench therefore checks each cycle against a model that counts those cycles. A lost attach-edge register shows as a spurious re-attach in the first cycle after recovery ends.

// File: rtl/drd_role_pkg.sv
package drd_role_pkg;
  typedef enum logic [2:0] {
    ST_DETACHED = 3'd0,
    ST_HOST     = 3'd1,
    ST_DEVICE   = 3'd2,
    ST_PREP     = 3'd3,
    ST_COMMIT   = 3'd4,
    ST_PROBE    = 3'd5,
    ST_RECOVER  = 3'd6
  } port_state_e;

  function automatic logic is_active(port_state_e s);
    return (s == ST_HOST) || (s == ST_DEVICE);
  endfunction
endpackage

// File: rtl/drd_cycle_timer.sv
module drd_cycle_timer #(
  parameter int TW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clear_i,
  input  logic [TW-1:0] limit_i,
  output logic          expired_o
);
  localparam logic [TW-1:0] CNT_MAX = {TW{1'b1}};

  logic [TW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || clear_i) begin
      cnt_q <= '0;
    end else if (cnt_q != CNT_MAX) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign expired_o = (cnt_q == limit_i);
endmodule

// File: rtl/drd_role_fsm.sv
module drd_role_fsm
  import drd_role_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        attach_i,
  input  logic        role_req_i,
  input  logic        req_host_i,
  input  logic        drain_done_i,
  input  logic        commit_done_i,
  input  logic        probe_pass_i,
  input  logic        probe_fail_i,
  input  logic        expired_i,
  output port_state_e cur_o,
  output port_state_e nxt_o,
  output logic        tgt_host_o,
  output logic        swap_ok_o
);
  port_state_e cur_q, nxt;
  logic        attach_q;
  logic        tgt_q, tgt_d;
  logic        ok_q, ok_d;
  logic        attach_evt;

  assign attach_evt = attach_i && !attach_q;

  always_comb begin
    nxt   = cur_q;
    tgt_d = tgt_q;
    ok_d  = ok_q;
    if (!attach_i) begin
      nxt = ST_DETACHED;
    end else begin
      unique case (cur_q)
        ST_DETACHED: if (attach_evt) nxt = req_host_i ? ST_HOST : ST_DEVICE;
        ST_HOST: if (role_req_i && !req_host_i) begin
          nxt   = ST_PREP;
          tgt_d = 1'b0;
        end
        ST_DEVICE: if (role_req_i && req_host_i) begin
          nxt   = ST_PREP;
          tgt_d = 1'b1;
        end
        ST_PREP: begin
          if (drain_done_i)   nxt = ST_COMMIT;
          else if (expired_i) nxt = ST_RECOVER;
        end
        ST_COMMIT: if (commit_done_i) nxt = ST_PROBE;
        ST_PROBE: begin
          if (probe_pass_i) begin
            nxt  = tgt_q ? ST_HOST : ST_DEVICE;
            ok_d = 1'b1;
          end else if (probe_fail_i || expired_i) begin
            nxt  = ST_RECOVER;
            ok_d = 1'b0;
          end
        end
        ST_RECOVER: if (expired_i) nxt = ST_DETACHED;
        default: nxt = ST_DETACHED;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cur_q    <= ST_DETACHED;
      attach_q <= 1'b0;
      tgt_q    <= 1'b0;
      ok_q     <= 1'b0;
    end else begin
      cur_q    <= nxt;
      attach_q <= attach_i;
      tgt_q    <= tgt_d;
      ok_q     <= ok_d;
    end
  end

  assign cur_o      = cur_q;
  assign nxt_o      = nxt;
  assign tgt_host_o = tgt_q;
  assign swap_ok_o  = ok_q;
endmodule

// File: rtl/drd_role_outs.sv
module drd_role_outs
  import drd_role_pkg::*;
#(
  parameter int HOST_EN_W = 3
) (
  input  logic                 clk,
  input  logic                 rst,
  input  port_state_e          cur_i,
  input  port_state_e          nxt_i,
  input  logic                 tgt_host_i,
  output logic                 admit_o,
  output logic                 drain_req_o,
  output logic                 role_host_o,
  output logic                 ctx_reinit_o,
  output logic                 probe_start_o,
  output logic [HOST_EN_W-1:0] host_en_o
);
  logic role_d;

  always_comb begin
    role_d = role_host_o;
    unique case (nxt_i)
      ST_HOST:                 role_d = 1'b1;
      ST_DEVICE,
      ST_DETACHED,
      ST_RECOVER:              role_d = 1'b0;
      ST_COMMIT: if (cur_i != ST_COMMIT) role_d = tgt_host_i;
      default:                 role_d = role_host_o;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      admit_o       <= 1'b0;
      drain_req_o   <= 1'b0;
      role_host_o   <= 1'b0;
      ctx_reinit_o  <= 1'b0;
      probe_start_o <= 1'b0;
    end else begin
      admit_o       <= is_active(nxt_i);
      drain_req_o   <= (nxt_i == ST_PREP);
      role_host_o   <= role_d;
      ctx_reinit_o  <= (nxt_i == ST_COMMIT) && (cur_i != ST_COMMIT);
      probe_start_o <= (nxt_i == ST_PROBE) && (cur_i != ST_PROBE);
    end
  end

  for (genvar g = 0; g < HOST_EN_W; g++) begin : g_host_en
    always_ff @(posedge clk) begin
      if (rst) host_en_o[g] <= 1'b0;
      else     host_en_o[g] <= (nxt_i == ST_HOST);
    end
  end
endmodule

// File: rtl/drd_role_seq.sv
module drd_role_seq
  import drd_role_pkg::*;
#(
  parameter int TW         = 8,
  parameter int REC_CYCLES = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          attach_i,
  input  logic          role_req_i,
  input  logic          req_host_i,
  input  logic          drain_done_i,
  input  logic          commit_done_i,
  input  logic          probe_pass_i,
  input  logic          probe_fail_i,
  input  logic [TW-1:0] prep_limit_i,
  input  logic [TW-1:0] probe_limit_i,
  output logic          admit_o,
  output logic          drain_req_o,
  output logic          role_host_o,
  output logic          ctx_reinit_o,
  output logic          probe_start_o,
  output logic          sof_en_o,
  output logic          port_rst_en_o,
  output logic          addr_en_o,
  output logic [2:0]    state_o,
  output logic          swap_ok_o
);
  localparam logic [TW-1:0] REC_LIM   = TW'(REC_CYCLES);
  localparam int            HOST_EN_W = 3;

  port_state_e          cur, nxt;
  logic                 tgt_host, expired;
  logic [TW-1:0]        limit;
  logic [HOST_EN_W-1:0] host_en;

  always_comb begin
    unique case (cur)
      ST_PREP:  limit = prep_limit_i;
      ST_PROBE: limit = probe_limit_i;
      default:  limit = REC_LIM;
    endcase
  end

  drd_cycle_timer #(.TW(TW)) u_timer (
    .clk       (clk),
    .rst       (rst),
    .clear_i   (nxt != cur),
    .limit_i   (limit),
    .expired_o (expired)
  );

  drd_role_fsm u_fsm (
    .clk           (clk),
    .rst           (rst),
    .attach_i      (attach_i),
    .role_req_i    (role_req_i),
    .req_host_i    (req_host_i),
    .drain_done_i  (drain_done_i),
    .commit_done_i (commit_done_i),
    .probe_pass_i  (probe_pass_i),
    .probe_fail_i  (probe_fail_i),
    .expired_i     (expired),
    .cur_o         (cur),
    .nxt_o         (nxt),
    .tgt_host_o    (tgt_host),
    .swap_ok_o     (swap_ok_o)
  );

  drd_role_outs #(.HOST_EN_W(HOST_EN_W)) u_outs (
    .clk           (clk),
    .rst           (rst),
    .cur_i         (cur),
    .nxt_i         (nxt),
    .tgt_host_i    (tgt_host),
    .admit_o       (admit_o),
    .drain_req_o   (drain_req_o),
    .role_host_o   (role_host_o),
    .ctx_reinit_o  (ctx_reinit_o),
    .probe_start_o (probe_start_o),
    .host_en_o     (host_en)
  );

  assign sof_en_o      = host_en[0];
  assign port_rst_en_o = host_en[1];
  assign addr_en_o     = host_en[2];
  assign state_o       = cur;
endmodule

// File: rtl/drd_role_seq_chk.sv
module drd_role_seq_chk (
  input logic       clk,
  input logic       rst,
  input logic       attach_i,
  input logic       admit_o,
  input logic       drain_req_o,
  input logic       ctx_reinit_o,
  input logic       probe_start_o,
  input logic       sof_en_o,
  input logic       port_rst_en_o,
  input logic       addr_en_o,
  input logic [2:0] state_o
);
  // R3: host-owned enables only in host state
  a_r3_host_only: assert property (@(posedge clk) disable iff (rst)
    (sof_en_o || port_rst_en_o || addr_en_o) |-> (state_o == 3'd1));

  // R4: quiesce while preparing a swap
  a_r4_prep_quiesce: assert property (@(posedge clk) disable iff (rst)
    (state_o == 3'd3) |-> (drain_req_o && !admit_o));

  // R2: admission only in an active role
  a_r2_admit_active: assert property (@(posedge clk) disable iff (rst)
    admit_o |-> (state_o == 3'd1 || state_o == 3'd2));

  // R6: commit is reached only through swap-prep
  a_r6_commit_path: assert property (@(posedge clk) disable iff (rst)
    (state_o == 3'd4) |-> ($past(state_o) == 3'd3 || $past(state_o) == 3'd4));

  // R6: reinit strobe only on the first commit cycle
  a_r6_reinit_entry: assert property (@(posedge clk) disable iff (rst)
    ctx_reinit_o |-> (state_o == 3'd4 && $past(state_o) == 3'd3));

  // R7: probe strobe only on entry from commit
  a_r7_probe_entry: assert property (@(posedge clk) disable iff (rst)
    probe_start_o |-> (state_o == 3'd5 && $past(state_o) == 3'd4));

  // R12: detach wins on the next edge
  a_r12_detach: assert property (@(posedge clk) disable iff (rst)
    !attach_i |=> (state_o == 3'd0));

  // R11: recovery exits only to detached
  a_r11_recover_exit: assert property (@(posedge clk) disable iff (rst)
    (state_o == 3'd6) |=> (state_o == 3'd6 || state_o == 3'd0));
endmodule

bind drd_role_seq drd_role_seq_chk u_chk (
  .clk           (clk),
  .rst           (rst),
  .attach_i      (attach_i),
  .admit_o       (admit_o),
  .drain_req_o   (drain_req_o),
  .ctx_reinit_o  (ctx_reinit_o),
  .probe_start_o (probe_start_o),
  .sof_en_o      (sof_en_o),
  .port_rst_en_o (port_rst_en_o),
  .addr_en_o     (addr_en_o),
  .state_o       (state_o)
);

// File: tb/drd_role_seq_bench.sv
module drd_role_seq_bench;
  localparam int TW  = 8;
  localparam int REC = 3;

  localparam int S_DET = 0, S_HOST = 1, S_DEV = 2, S_PREP = 3,
                 S_COMMIT = 4, S_PROBE = 5, S_REC = 6;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic att = 1'b0, rreq = 1'b0, rhost = 1'b0, dd = 1'b0, cd = 1'b0, pp = 1'b0, pf = 1'b0;
  logic [TW-1:0] plim = 8'd4, qlim = 8'd4;
  logic admit, drain, role, reinit, pstart, sof, prst, aen, ok;
  logic [2:0] st;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // reference model state
  int m_st = S_DET, m_cnt = 0;
  bit m_attq = 0, m_tgt = 0, m_role = 0, m_ok = 0, m_reinit = 0, m_pstart = 0;

  always #2.5 clk = ~clk;

  drd_role_seq #(.TW(TW), .REC_CYCLES(REC)) u_drd_role_seq (
    .clk(clk), .rst(rst), .attach_i(att), .role_req_i(rreq), .req_host_i(rhost),
    .drain_done_i(dd), .commit_done_i(cd), .probe_pass_i(pp), .probe_fail_i(pf),
    .prep_limit_i(plim), .probe_limit_i(qlim),
    .admit_o(admit), .drain_req_o(drain), .role_host_o(role), .ctx_reinit_o(reinit),
    .probe_start_o(pstart), .sof_en_o(sof), .port_rst_en_o(prst), .addr_en_o(aen),
    .state_o(st), .swap_ok_o(ok));

  task automatic chk(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  function automatic int lim_of(int s);
    if (s == S_PREP)  return int'(plim);
    if (s == S_PROBE) return int'(qlim);
    return REC;
  endfunction

  // next state of the model from the requirements
  function automatic int model_next();
    int n = m_st;
    if (!att) return S_DET;
    case (m_st)
      S_DET:    if (att && !m_attq) n = rhost ? S_HOST : S_DEV;
      S_HOST:   if (rreq && !rhost) n = S_PREP;
      S_DEV:    if (rreq && rhost)  n = S_PREP;
      S_PREP:   if (dd) n = S_COMMIT; else if (m_cnt == lim_of(S_PREP)) n = S_REC;
      S_COMMIT: if (cd) n = S_PROBE;
      S_PROBE:  if (pp) n = m_tgt ? S_HOST : S_DEV;
                else if (pf || m_cnt == lim_of(S_PROBE)) n = S_REC;
      S_REC:    if (m_cnt == REC) n = S_DET;
      default:  n = S_DET;
    endcase
    return n;
  endfunction

  task automatic model_update();
    int n = model_next();
    if (m_st == S_PROBE && att) begin
      if (pp) m_ok = 1;
      else if (n == S_REC) m_ok = 0;
    end
    if (n == S_PREP && m_st != S_PREP) m_tgt = (m_st == S_DEV);
    m_reinit = (n == S_COMMIT && m_st != S_COMMIT);
    m_pstart = (n == S_PROBE && m_st != S_PROBE);
    if (n == S_HOST) m_role = 1;
    else if (n == S_DEV || n == S_DET || n == S_REC) m_role = 0;
    else if (m_reinit) m_role = m_tgt;
    m_cnt  = (n != m_st) ? 0 : ((m_cnt == 255) ? 255 : m_cnt + 1);
    m_st   = n;
    m_attq = att;
  endtask

  task automatic cmp_model();
    bit h = (m_st == S_HOST);
    chk("R13", "state", st, m_st);
    chk("R2", "admit", admit, (m_st == S_HOST || m_st == S_DEV));
    chk("R4", "drain_req", drain, (m_st == S_PREP));
    chk("R3", "sof_en", sof, h);
    chk("R3", "port_rst_en", prst, h);
    chk("R3", "addr_en", aen, h);
    chk("R6", "role_host", role, m_role);
    chk("R6", "ctx_reinit", reinit, m_reinit);
    chk("R7", "probe_start", pstart, m_pstart);
    chk("R8", "swap_ok", ok, m_ok);
  endtask

  // drive inputs (already set), advance one clock, compare with model
  task automatic step();
    model_update();
    @(posedge clk);
    @(negedge clk);
    cmp_model();
    rreq = 0; dd = 0; cd = 0; pp = 0; pf = 0;
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual running expected finished");
      summary();
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1", "state in reset", st, S_DET);
    chk("R1", "outputs in reset", {admit, drain, role, reinit, pstart, sof, prst, aen, ok}, 0);
    rst = 0;
    @(negedge clk);
    chk("R1", "state after reset", st, S_DET);

    // R2: attach as host
    att = 1; rhost = 1; step();
    chk("R2", "attach host", st, S_HOST);
    chk("R3", "sof in host", sof, 1);
    // R5: same-role request ignored
    rreq = 1; rhost = 1; step();
    chk("R5", "same-role req state", st, S_HOST);
    chk("R5", "same-role req admit", admit, 1);
    // R4: swap to device
    rreq = 1; rhost = 0; step();
    chk("R4", "prep state", st, S_PREP);
    chk("R4", "prep admit", admit, 0);
    chk("R4", "prep role held", role, 1);
    chk("R3", "sof off in prep", sof, 0);
    rreq = 1; rhost = 1; step();
    chk("R5", "req ignored in prep", st, S_PREP);
    dd = 1; step();
    chk("R6", "commit state", st, S_COMMIT);
    chk("R6", "reinit pulse", reinit, 1);
    chk("R6", "role now device", role, 0);
    step();
    chk("R6", "reinit one cycle", reinit, 0);
    chk("R7", "waits commit_done", st, S_COMMIT);
    cd = 1; step();
    chk("R7", "probe state", st, S_PROBE);
    chk("R7", "probe start", pstart, 1);
    pp = 1; pf = 1; step();
    chk("R8", "pass wins", st, S_DEV);
    chk("R8", "admit restored", admit, 1);
    chk("R8", "swap ok", ok, 1);

    // R9: probe fail
    rreq = 1; rhost = 1; step();
    dd = 1; step();
    chk("R6", "role now host", role, 1);
    cd = 1; step();
    pf = 1; step();
    chk("R9", "probe fail", st, S_REC);
    chk("R9", "swap ok cleared", ok, 0);
    // R11: recovery length and no re-attach
    for (int i = 0; i < REC; i++) begin
      step();
      chk("R11", "still recovering", st, S_REC);
    end
    step();
    chk("R11", "back to detached", st, S_DET);
    chk("R11", "outputs idle", {admit, drain, role, sof}, 0);
    step(); step();
    chk("R11", "no attach without edge", st, S_DET);
    att = 0; step();
    att = 1; rhost = 0; step();
    chk("R2", "attach device", st, S_DEV);

    // R10: prep timeout with limit 2
    plim = 8'd2;
    rreq = 1; rhost = 1; step();
    step(); step();
    chk("R10", "prep before limit", st, S_PREP);
    step();
    chk("R10", "prep timeout", st, S_REC);
    repeat (REC + 1) step();

    // R9: probe timeout with limit 1
    att = 0; step();
    att = 1; rhost = 0; step();
    qlim = 8'd1;
    rreq = 1; rhost = 1; step();
    dd = 1; step();
    cd = 1; step();
    step();
    chk("R9", "probe before limit", st, S_PROBE);
    step();
    chk("R9", "probe timeout", st, S_REC);

    // R12: detach from commit
    repeat (REC + 1) step();
    att = 0; step();
    att = 1; rhost = 1; step();
    rreq = 1; rhost = 0; step();
    dd = 1; step();
    att = 0; step();
    chk("R12", "detach forces detached", st, S_DET);
    chk("R12", "detach clears role", role, 0);

    // random phase
    for (int i = 0; i < 4000; i++) begin
      att   = ($urandom_range(99) < 97);
      rreq  = ($urandom_range(99) < 20);
      rhost = $urandom_range(1);
      dd    = ($urandom_range(99) < 25);
      cd    = ($urandom_range(99) < 40);
      pp    = ($urandom_range(99) < 20);
      pf    = ($urandom_range(99) < 10);
      if ((i % 500) == 0) begin
        plim = 8'($urandom_range(6));
        qlim = 8'($urandom_range(6));
      end
      step();
    end

    done = 1;
    summary();
    $finish;
  end
endmodule